// File: doc/BRIEF.md
# Two-Phase Seven-Bit DDR Word Assembler

This block sits behind a double-data-rate input stage on a serial video link. Each lane carries seven bits per pixel. The input stage hands the block two bits per sample-clock cycle for every lane: the bit captured on the rising edge, then the bit captured on the falling edge. The sample clock runs at 3.5 times the pixel rate, so two pixels span exactly seven sample cycles. Seven is odd, so pixel boundaries fall after a rising-edge bit for one pixel and after a falling-edge bit for the next. A two-phase tracker follows this alternation.

The link's clock lane is deserialized in the same way as the data lanes. Its fixed seven-bit shape marks where each pixel starts and ends. Once that shape has repeated at the expected spacing enough times, the block declares lock. From then on it emits one registered parallel word per pixel, together with a one-cycle strobe. The data lanes lag the clock lane by two bit times, and the block takes this into account when it picks the data window.

Top module: `ddr7_deser`

## Requirements
- R1: After reset, `locked`, `pixValid` and `pixWord` are all zero.
- R2: In each cycle, the rising-edge bit precedes the falling-edge bit in time. In each 7-bit lane word, the earliest bit is the MSB. Lane L fills `pixWord[7L+6:7L]`.
- R3: A pixel boundary on the clock lane is the 7-bit pattern 1100011, earliest bit first. `locked` rises only after four consecutive matches spaced seven bits apart.
- R4: The data-lane bits of a pixel start two bit times after that pixel's clock-lane bits.
- R5: The first word emitted after lock is the pixel whose clock word gave the fourth match. After that, every pixel is emitted in order and none is skipped. `pixWord` holds its value between strobes.
- R6: While locked, the intervals between `pixValid` strobes alternate between 3 and 4 sample cycles, and each strobe lasts one cycle.
- R7: If the pattern is missing at an expected boundary, lock is dropped at once and that pixel is not emitted. Regaining lock takes four new matches.
- R8: Lock and word recovery work for any starting bit offset of the stream, including boundaries on either edge.
- R9: `pixValid` is never high while `locked` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataRise | input | LANES | Rising-edge bit of each data lane |
| dataFall | input | LANES | Falling-edge bit of each data lane |
| clkLaneRise | input | 1 | Rising-edge bit of the clock lane |
| clkLaneFall | input | 1 | Falling-edge bit of the clock lane |
| pixWord | output | 7*LANES | Assembled pixel word |
| pixValid | output | 1 | One-cycle strobe per emitted pixel |
| locked | output | 1 | Framing lock indicator |

## Verification
The assertions check several properties on every cycle:
- the phase counter stays in range;
- a missed pattern at an expected boundary clears lock on the next cycle;
- lock never rises without a pattern match;
- the strobe is a single cycle and only occurs under lock;
- the word holds between captures.

Only the bench scenarios can show the rest. They sweep every one of the fourteen starting bit offsets, and in each one the bench compares the recovered words with the transmitted pixels. This covers bit order, lane placement, the two-bit data lag, which pixel comes first after lock, and the alternating 3/4 strobe cadence. Two further scenarios corrupt one clock word to show that lock is dropped, the affected pixels are skipped, and the four-match relock follows.

// File: rtl/ddr7_pkg.sv
package ddr7_pkg;
  localparam int WORD = 7;
  localparam logic [WORD-1:0] CLK_PAT = 7'b1100011;

  typedef struct packed {
    logic capture;
    logic selRise;
  } capCtl_t;
endpackage

// File: rtl/ddr7_datapath.sv
module ddr7_datapath
  import ddr7_pkg::*;
#(
  parameter int LANES = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LANES-1:0]      laneRise,
  input  logic [LANES-1:0]      laneFall,
  input  logic                  clkRise,
  input  logic                  clkFall,
  input  capCtl_t               ctl,
  output logic                  matchRise,
  output logic                  matchFall,
  output logic [LANES*WORD-1:0] pixWord,
  output logic                  pixValid
);
  localparam int SRW = WORD + 1;

  logic [SRW-1:0]        ckSr;
  logic [LANES*WORD-1:0] laneWord;

  // Clock lane: two bits per cycle, falling-edge bit is the newest (LSB)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ckSr <= '0;
    else       ckSr <= {ckSr[SRW-3:0], clkRise, clkFall};
  end

  assign matchFall = (ckSr[WORD-1:0] == CLK_PAT);
  assign matchRise = (ckSr[WORD:1]   == CLK_PAT);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SRW-1:0] sr;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sr <= '0;
      else       sr <= {sr[SRW-3:0], laneRise[l], laneFall[l]};
    end
    assign laneWord[l*WORD +: WORD] = ctl.selRise ? sr[WORD:1] : sr[WORD-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixWord  <= '0;
      pixValid <= 1'b0;
    end else begin
      pixValid <= ctl.capture;
      if (ctl.capture) pixWord <= laneWord;
    end
  end

  // R6: strobe lasts a single cycle
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> !pixValid);

  // R5: word only changes on a capture
  p_word_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(pixWord));
endmodule

// File: rtl/ddr7_control.sv
module ddr7_control
  import ddr7_pkg::*;
#(
  parameter int OFFSET_BITS = 2,
  parameter int LOCK_RUNS   = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    matchRise,
  input  logic    matchFall,
  output capCtl_t ctl,
  output logic    locked
);
  localparam int DLY  = OFFSET_BITS / 2;
  localparam int RUNW = $clog2(LOCK_RUNS + 1);

  typedef enum logic {HUNT, TRACK} st_t;

  st_t            st, stNext;
  logic [2:0]     cnt, cntNext;
  logic [RUNW-1:0] run, runNext;
  logic           hitNow, atBound, expHit;
  capCtl_t        capNow;

  assign atBound = (st == TRACK) && (cnt == 3'd3 || cnt == 3'd6);
  assign expHit  = (cnt == 3'd3) ? matchRise : matchFall;

  always_comb begin
    stNext  = st;
    cntNext = cnt;
    runNext = run;
    hitNow  = 1'b0;
    capNow  = '0;
    if (st == HUNT) begin
      if (matchRise) begin
        stNext = TRACK; cntNext = 3'd4; runNext = RUNW'(1);
        hitNow = 1'b1;  capNow.selRise = 1'b1;
      end else if (matchFall) begin
        stNext = TRACK; cntNext = 3'd0; runNext = RUNW'(1);
        hitNow = 1'b1;
      end
    end else begin
      cntNext = (cnt == 3'd6) ? 3'd0 : cnt + 3'd1;
      if (atBound) begin
        capNow.selRise = (cnt == 3'd3);
        if (expHit) begin
          hitNow = 1'b1;
          if (run < RUNW'(LOCK_RUNS)) runNext = run + RUNW'(1);
        end else begin
          stNext  = HUNT;
          runNext = '0;
        end
      end
    end
    capNow.capture = hitNow && (runNext >= RUNW'(LOCK_RUNS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= HUNT;
      cnt    <= '0;
      run    <= '0;
      locked <= 1'b0;
    end else begin
      st     <= stNext;
      cnt    <= cntNext;
      run    <= runNext;
      locked <= (stNext == TRACK) && (runNext >= RUNW'(LOCK_RUNS));
    end
  end

  // Data lags the clock lane by OFFSET_BITS bits = DLY sample cycles
  if (DLY == 0) begin : g_nodly
    assign ctl = capNow;
  end else begin : g_dly
    capCtl_t pipe [DLY];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < DLY; i++) pipe[i] <= '0;
      end else begin
        pipe[0] <= capNow;
        for (int i = 1; i < DLY; i++) pipe[i] <= pipe[i-1];
      end
    end
    assign ctl = pipe[DLY-1];
  end

  // R6: phase counter never leaves the 7-cycle group
  p_phase_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    st == TRACK |-> cnt <= 3'd6);

  // R7: missing pattern at an expected boundary drops lock
  p_miss_drops_lock_r7: assert property (@(posedge clk) disable iff (!rstN)
    (atBound && !expHit) |=> !locked);

  // R3: lock only rises on a cycle following a pattern match
  p_lock_from_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(matchRise || matchFall));
endmodule

// File: rtl/ddr7_deser.sv
module ddr7_deser
  import ddr7_pkg::*;
#(
  parameter int LANES       = 3,
  parameter int OFFSET_BITS = 2,
  parameter int LOCK_RUNS   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LANES-1:0]      dataRise,
  input  logic [LANES-1:0]      dataFall,
  input  logic                  clkLaneRise,
  input  logic                  clkLaneFall,
  output logic [LANES*WORD-1:0] pixWord,
  output logic                  pixValid,
  output logic                  locked
);
  capCtl_t ctl;
  logic    matchRise, matchFall;

  ddr7_control #(.OFFSET_BITS(OFFSET_BITS), .LOCK_RUNS(LOCK_RUNS)) u_ctl (
    .clk(clk), .rstN(rstN), .matchRise(matchRise), .matchFall(matchFall),
    .ctl(ctl), .locked(locked)
  );

  ddr7_datapath #(.LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .laneRise(dataRise), .laneFall(dataFall),
    .clkRise(clkLaneRise), .clkFall(clkLaneFall), .ctl(ctl),
    .matchRise(matchRise), .matchFall(matchFall),
    .pixWord(pixWord), .pixValid(pixValid)
  );

  // R9: a strobe never appears without lock
  p_valid_locked_r9: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> locked);
endmodule

// File: tb/sim_ddr7_deser.sv
module sim_ddr7_deser;
  localparam int LANES = 3;
  localparam int NPIX  = 24;
  localparam logic [6:0] PAT = 7'b1100011;

  logic clk = 0, rstN = 0;
  logic [LANES-1:0] dataRise = '0, dataFall = '0;
  logic clkLaneRise = 0, clkLaneFall = 0;
  logic [LANES*7-1:0] pixWord;
  logic pixValid, locked;

  int nChk = 0, nFail = 0;
  int cyc = 0, gotCnt = 0, gapBad = 0, vUnlock = 0;
  int lastV = -1, prevGap = 0, sawLock = 0, lostLock = 0;
  int gotIdx [64];

  always #2.5 clk = ~clk;

  ddr7_deser #(.LANES(LANES)) u0 (
    .clk(clk), .rstN(rstN), .dataRise(dataRise), .dataFall(dataFall),
    .clkLaneRise(clkLaneRise), .clkLaneFall(clkLaneFall),
    .pixWord(pixWord), .pixValid(pixValid), .locked(locked)
  );

  function automatic logic [20:0] pixOf(input int n);
    return 21'(n) * 21'h0A5A3 + 21'h13579;
  endfunction

  function automatic logic clkBit(input int i, input int s, input int bad);
    int j = i - s;
    if (j < 0) return 1'b0;
    if (j / 7 == bad) return 1'b0;
    return PAT[6 - (j % 7)];
  endfunction

  function automatic logic dataBit(input int i, input int s, input int lane);
    int j = i - s - 2;
    logic [20:0] w;
    if (j < 0) return 1'b0;
    w = pixOf(j / 7);
    return w[7*lane + 6 - (j % 7)];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int idx, gap;
    #1;
    cyc++;
    if (!locked) begin lastV = -1; prevGap = 0; end
    if (locked) sawLock = 1;
    if (!locked && sawLock != 0) lostLock = 1;
    if (pixValid) begin
      if (!locked) vUnlock++;
      idx = -1;
      for (int n = 0; n < 64; n++) if (pixOf(n) == pixWord) idx = n;
      if (gotCnt < 64) gotIdx[gotCnt] = idx;
      gotCnt++;
      if (lastV >= 0) begin
        gap = cyc - lastV;
        if (gap != 3 && gap != 4) gapBad++;
        if (prevGap != 0 && gap == prevGap) gapBad++;
        prevGap = gap;
      end
      lastV = cyc;
    end
  end

  task automatic runCase(input int s, input int bad);
    int nBits, expCnt, k, mism, lockEnd;
    int expIdx [64];
    rstN = 0; dataRise = '0; dataFall = '0; clkLaneRise = 0; clkLaneFall = 0;
    repeat (3) @(negedge clk);
    chk(locked == 0 && pixValid == 0 && pixWord == '0, "R1 reset state",
        int'(locked) + int'(pixValid), 0);
    gotCnt = 0; gapBad = 0; vUnlock = 0; lastV = -1; prevGap = 0;
    sawLock = 0; lostLock = 0;
    rstN = 1;
    nBits = s + 7 * NPIX + 16;
    for (int c = 0; c < (nBits + 1) / 2; c++) begin
      @(negedge clk);
      clkLaneRise = clkBit(2*c, s, bad);
      clkLaneFall = clkBit(2*c + 1, s, bad);
      for (int l = 0; l < LANES; l++) begin
        dataRise[l] = dataBit(2*c, s, l);
        dataFall[l] = dataBit(2*c + 1, s, l);
      end
    end
    repeat (2) @(negedge clk);
    lockEnd = int'(locked);
    expCnt = 0;
    for (int n = 3; n < NPIX; n++)
      if (!(bad >= 0 && n >= bad && n < bad + 4)) begin
        expIdx[expCnt] = n; expCnt++;
      end
    // R5 / R8: first pixel after the fourth match
    chk(gotCnt > 0 && gotIdx[0] == 3, "R5 R8 first word after lock",
        gotCnt > 0 ? gotIdx[0] : -2, 3);
    chk(gotCnt >= expCnt, "R5 word count", gotCnt, expCnt);
    // R2 / R4: bit order, lane placement and 2-bit data lag
    mism = 0; k = -1;
    for (int i = 0; i < expCnt && i < gotCnt && i < 64; i++)
      if (gotIdx[i] != expIdx[i] && k < 0) begin k = i; mism++; end
    chk(mism == 0, "R2 R4 R5 word sequence", k < 0 ? -1 : gotIdx[k],
        k < 0 ? -1 : expIdx[k]);
    chk(gapBad == 0, "R6 strobe cadence", gapBad, 0);
    chk(vUnlock == 0, "R9 strobe without lock", vUnlock, 0);
    chk(lockEnd == 1, "R3 locked on steady stream", lockEnd, 1);
    if (bad >= 0) chk(lostLock == 1, "R7 lock dropped on bad word", lostLock, 1);
  endtask

  initial begin
    #(5.0 * 100000);
    nChk++; nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    // R8: all fourteen bit offsets, both boundary parities
    for (int s = 0; s < 14; s++) runCase(s, -1);
    // R7: corrupted clock word at two alignments
    runCase(5, 10);
    runCase(8, 12);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule